// File: doc/BRIEF.md
# Programmable clock phase-duty generator

This block turns a reference clock into phase-shifted or duty-adjusted clocks using only synchronous logic. It runs on a sampling clock that is 32 times the reference rate, so every reference period is split into 32 equal phase slots of 3.125% each. The block counts slots, and it restarts the count on each rising edge of the reference, after an optional pre-divider.

An 8-bit tap register holds a value from 1 to 31 in a packed, irregular layout. One mode bit picks how that tap is used. In delayed-clock mode the output is a 50% copy of the reference, shifted by the tap in slots. In duty mode the output is high for the first tap slots of each period.

Two outputs select from these sources:
- The I/O-side clock can also take the delayed clock divided by 1 to 8.
- The system clock has no divider.

Configuration is captured only at a period start, so a change made mid-period never truncates a pulse.

Top module: `clk_phase_gen`

## Requirements
- R1: While `rst_ni` is low, and after reset until the first rising edge of `ref_clk_i` is sampled, both outputs are low.
- R2: Let N be `cfg_prediv_i`+1. The edge of `clk_i` that first samples `ref_clk_i` high starts a period. From then on, every N-th such edge starts a period. A period has 32 slots of N cycles each. Slot s covers the N cycles after the edges e+sN … e+sN+N-1, where e is the starting edge.
- R3: The tap T is decoded from `cfg_tap_i` by its bits [7:6]:
  - 00: T = bits[2:0]+1.
  - 01: T = bits[2:0]+9, except that bits[5:3]=111 gives 16.
  - 10: T = bits[5:3]+17.
  - 11: T = bits[5:3]+25, limited to 31.
- R4: With `cfg_mode_i` bit0=0 and bit4=0 (delayed mode), the delayed clock is high in slot s exactly when (s−T) mod 32 < 16. It is low in duty mode.
- R5: With bit0=0 and bit4=1 (duty mode), the duty clock is high in slot s exactly when s < T. It is low in delayed mode.
- R6: `sys_clk_o` follows `cfg_osel_i`[7:6]:
  - 01: the duty clock.
  - 10: the delayed clock.
  - 00 or 11: low.
- R7: `io_clk_o` follows `cfg_osel_i`[5:4]:
  - 01: the duty clock.
  - 10: the delayed clock.
  - 11: the divided delayed clock.
  - 00: low.
- R8: Let M be `cfg_iodiv_i`+1. For M=1 the divided clock equals the delayed clock. For M≥2, number the delayed-clock rising edges from 1 after reset. From rising edge k until the next one, the divided clock is high exactly when (k mod M) < floor(M/2). Before the first rising edge k counts as 0. The divided clock is low in duty mode.
- R9: With `cfg_mode_i` bit0=1, both outputs stay low.
- R10: All configuration inputs are captured at a period start. A change made mid-period has no effect until the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, 32x the reference rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_clk_i | input | 1 | Reference clock, synchronous to clk_i |
| cfg_mode_i | input | 8 | Mode: bit0 disables, bit4 selects duty mode |
| cfg_tap_i | input | 8 | Packed tap code |
| cfg_osel_i | input | 8 | Output selects: [5:4] I/O clock, [7:6] system clock |
| cfg_iodiv_i | input | 3 | I/O divisor minus one |
| cfg_prediv_i | input | 3 | Reference pre-divisor minus one |
| io_clk_o | output | 1 | I/O-side clock |
| sys_clk_o | output | 1 | System clock |

## Verification
Every cycle of each run is compared against a slot-by-slot model. Directed cases cover the tap boundaries: 1, 8, 14, 16, 20, and 31, including the clamped code. Runs with taps on both sides of 16 separate a delayed copy that wraps into slot 0 from one that does not. Pre-divided runs show whether a slot lasts N cycles and whether realignment happens only on every N-th reference edge. Odd and even I/O divisors show the divided clock's period and high time. Select codes that mismatch the mode, the disable bit, and a mid-period tap change show that unused sources stay low and that changes wait for the boundary. Seeded random settings then cover mixed combinations.

// File: rtl/cph_pkg.sv
package cph_pkg;
  localparam int SLOT_W        = 5;
  localparam int NUM_SLOTS     = 1 << SLOT_W;
  localparam int REG_W         = 8;
  localparam int DIV_W         = 3;
  localparam int MODE_OFF_BIT  = 0;
  localparam int MODE_DUTY_BIT = 4;

  typedef enum logic [1:0] {
    SEL_LOW  = 2'b00,
    SEL_DUTY = 2'b01,
    SEL_DLY  = 2'b10,
    SEL_DIV  = 2'b11
  } sel_e;

  typedef struct packed {
    logic [REG_W-1:0] mode;
    logic [REG_W-1:0] tap;
    logic [REG_W-1:0] osel;
    logic [DIV_W-1:0] iodiv;
    logic [DIV_W-1:0] prediv;
  } cfg_t;

  // packed tap code -> 1..31
  function automatic logic [SLOT_W-1:0] decode_tap(input logic [REG_W-1:0] r);
    logic [SLOT_W:0] t;
    case (r[7:6])
      2'b00:   t = {3'b000, r[2:0]} + 6'd1;
      2'b01:   t = (r[5:3] == 3'b111) ? 6'd16 : {3'b000, r[2:0]} + 6'd9;
      2'b10:   t = {3'b000, r[5:3]} + 6'd17;
      default: t = {3'b000, r[5:3]} + 6'd25;
    endcase
    return (t > 6'd31) ? 5'd31 : t[SLOT_W-1:0];
  endfunction
endpackage

// File: rtl/cph_period_track.sv
module cph_period_track #(
  parameter int SLOT_W = 5,
  parameter int DIV_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_i,
  input  logic [DIV_W-1:0]  div_m1_i,
  output logic              per_start_o,
  output logic              slot_tick_o,
  output logic [SLOT_W-1:0] slot_nxt_o
);
  logic              ref_q;
  logic [DIV_W-1:0]  edge_q;
  logic [DIV_W-1:0]  sub_q;
  logic [DIV_W-1:0]  sub_nxt;
  logic [SLOT_W-1:0] slot_q;
  logic              rise;

  assign rise        = ref_i & ~ref_q;
  assign per_start_o = rise & (edge_q == '0);

  always_comb begin
    if (per_start_o) begin
      sub_nxt    = '0;
      slot_nxt_o = '0;
    end else if (sub_q >= div_m1_i) begin
      sub_nxt    = '0;
      slot_nxt_o = slot_q + 1'b1;
    end else begin
      sub_nxt    = sub_q + 1'b1;
      slot_nxt_o = slot_q;
    end
  end

  assign slot_tick_o = (sub_nxt == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= 1'b0;
      edge_q <= '0;
      sub_q  <= '0;
      slot_q <= '0;
    end else begin
      ref_q  <= ref_i;
      sub_q  <= sub_nxt;
      slot_q <= slot_nxt_o;
      if (rise) edge_q <= (edge_q >= div_m1_i) ? '0 : edge_q + 1'b1;
    end
  end

  assert_realign_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_start_o |=> (slot_q == '0) && (sub_q == '0));
endmodule

// File: rtl/cph_io_div.sv
module cph_io_div #(
  parameter int DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dly_i,
  input  logic [DIV_W-1:0] div_m1_i,
  output logic             div_o
);
  logic             dly_q;
  logic             rise;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_nxt;
  logic [DIV_W:0]   half;

  assign rise    = dly_i & ~dly_q;
  assign cnt_nxt = rise ? ((cnt_q >= div_m1_i) ? '0 : cnt_q + 1'b1) : cnt_q;
  assign half    = ({1'b0, div_m1_i} + 1'b1) >> 1;
  assign div_o   = (div_m1_i == '0) ? dly_i : ({1'b0, cnt_nxt} < half);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      dly_q <= dly_i;
      cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/clk_phase_gen.sv
module clk_phase_gen
  import cph_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_clk_i,
  input  logic [REG_W-1:0] cfg_mode_i,
  input  logic [REG_W-1:0] cfg_tap_i,
  input  logic [REG_W-1:0] cfg_osel_i,
  input  logic [DIV_W-1:0] cfg_iodiv_i,
  input  logic [DIV_W-1:0] cfg_prediv_i,
  output logic             io_clk_o,
  output logic             sys_clk_o
);
  cfg_t              cfg_in, cfg_q, cfg_nxt;
  logic              armed_q, armed_nxt;
  logic              per_start, slot_tick;
  logic [SLOT_W-1:0] slot_nxt, tap, diff;
  logic              en, duty_mode, duty_nxt, dly_nxt, div_raw, div_nxt;
  logic              io_nxt, sys_nxt;

  assign cfg_in = '{mode: cfg_mode_i, tap: cfg_tap_i, osel: cfg_osel_i,
                    iodiv: cfg_iodiv_i, prediv: cfg_prediv_i};

  // shadow loads only at a period start
  assign cfg_nxt   = per_start ? cfg_in : cfg_q;
  assign armed_nxt = armed_q | per_start;

  cph_period_track #(.SLOT_W(SLOT_W), .DIV_W(DIV_W)) i_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ref_i       (ref_clk_i),
    .div_m1_i    (cfg_nxt.prediv),
    .per_start_o (per_start),
    .slot_tick_o (slot_tick),
    .slot_nxt_o  (slot_nxt)
  );

  assign tap       = decode_tap(cfg_nxt.tap);
  assign en        = armed_nxt & ~cfg_nxt.mode[MODE_OFF_BIT];
  assign duty_mode = cfg_nxt.mode[MODE_DUTY_BIT];
  assign diff      = slot_nxt - tap;
  assign duty_nxt  = en & duty_mode & (slot_nxt < tap);
  assign dly_nxt   = en & ~duty_mode & ~diff[SLOT_W-1];

  cph_io_div #(.DIV_W(DIV_W)) i_io_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dly_i    (dly_nxt),
    .div_m1_i (cfg_nxt.iodiv),
    .div_o    (div_raw)
  );

  assign div_nxt = div_raw & en & ~duty_mode;

  function automatic logic pick(input sel_e s, input logic d, input logic y, input logic v);
    case (s)
      SEL_DUTY: return d;
      SEL_DLY:  return y;
      SEL_DIV:  return v;
      default:  return 1'b0;
    endcase
  endfunction

  assign io_nxt  = pick(sel_e'(cfg_nxt.osel[5:4]), duty_nxt, dly_nxt, div_nxt);
  assign sys_nxt = pick(sel_e'(cfg_nxt.osel[7:6]), duty_nxt, dly_nxt, 1'b0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      armed_q   <= 1'b0;
      io_clk_o  <= 1'b0;
      sys_clk_o <= 1'b0;
    end else begin
      cfg_q     <= cfg_nxt;
      armed_q   <= armed_nxt;
      io_clk_o  <= io_nxt;
      sys_clk_o <= sys_nxt;
    end
  end

  assert_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> (!io_clk_o && !sys_clk_o));

  assert_duty_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_start && !cfg_mode_i[MODE_OFF_BIT] && cfg_mode_i[MODE_DUTY_BIT]
     && cfg_osel_i[7:6] == 2'b01) |=> sys_clk_o);

  assert_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_start && cfg_mode_i[MODE_OFF_BIT]) |=> (!io_clk_o && !sys_clk_o));

  assert_no_runt_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sys_clk_o != $past(sys_clk_o)) || (io_clk_o != $past(io_clk_o)))
      |-> $past(slot_tick));
endmodule

// File: tb/test_clk_phase_gen.sv
`timescale 1ns/1ps
module test_clk_phase_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ref_clk = 1'b0;
  logic [7:0] mode = '0, tap = '0, osel = '0;
  logic [2:0] iodiv = '0, prediv = '0;
  logic       io_clk, sys_clk;

  int    vectors = 0, fails = 0;
  bit    run_en = 1'b0;
  int    tick = -1;
  string cur_req = "R1";
  logic [7:0] e_mode, e_tap, e_osel;
  int    e_m = 1;
  int    k = 0;
  bit    pdly = 1'b0;

  always #2.5 clk_i = ~clk_i;

  clk_phase_gen i_clk_phase_gen (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ref_clk_i    (ref_clk),
    .cfg_mode_i   (mode),
    .cfg_tap_i    (tap),
    .cfg_osel_i   (osel),
    .cfg_iodiv_i  (iodiv),
    .cfg_prediv_i (prediv),
    .io_clk_o     (io_clk),
    .sys_clk_o    (sys_clk)
  );

  // R3 tap decode as specified
  function automatic int tap_of(input logic [7:0] r);
    int lo = int'(r[2:0]);
    int mid = int'(r[5:3]);
    case (r[7:6])
      2'b00: return lo + 1;
      2'b01: return (mid == 7) ? 16 : lo + 9;
      2'b10: return mid + 17;
      default: return (mid + 25 > 31) ? 31 : mid + 25;
    endcase
  endfunction

  function automatic bit pick(input logic [1:0] s, input bit d, input bit y, input bit v);
    case (s)
      2'b01: return d;
      2'b10: return y;
      2'b11: return v;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check2(input string req, input logic io_a, input logic sys_a,
                        input bit io_e, input bit sys_e);
    vectors++;
    if (io_a !== io_e || sys_a !== sys_e) begin
      fails++;
      $display("FAIL %s: io/sys got %b%b expected %b%b (tick %0d)",
               req, io_a, sys_a, io_e, sys_e, tick);
    end
  endtask

  task automatic check_cycle();
    int n = int'(prediv) + 1;
    int j = tick % (32 * n);
    int slot, t;
    bit on, dm, ed, ey, ediv;
    if (j == 0) begin
      e_mode = mode; e_tap = tap; e_osel = osel; e_m = int'(iodiv) + 1;
    end
    slot = j / n;
    t    = tap_of(e_tap);
    on   = !e_mode[0];
    dm   = e_mode[4];
    ed   = on && dm && (slot < t);                        // R5
    ey   = on && !dm && (((slot - t + 32) % 32) < 16);    // R4
    if (ey && !pdly) k++;
    pdly = ey;
    if (!(on && !dm)) ediv = 1'b0;                        // R8
    else if (e_m == 1) ediv = ey;
    else ediv = (k % e_m) < (e_m / 2);
    check2(cur_req, io_clk, sys_clk,
           pick(e_osel[5:4], ed, ey, ediv),               // R7
           pick(e_osel[7:6], ed, ey, 1'b0));              // R6
  endtask

  always @(negedge clk_i) begin
    if (!run_en) begin
      tick = -1; ref_clk = 1'b0; k = 0; pdly = 1'b0;
    end else begin
      if (tick >= 0) check_cycle();
      tick++;
      ref_clk = ((tick % 32) < 16);
    end
  end

  task automatic run_cfg(input logic [7:0] m, input logic [7:0] t, input logic [7:0] o,
                         input logic [2:0] d, input logic [2:0] p, input int periods,
                         input string req);
    @(posedge clk_i); #1;
    run_en = 1'b0; rst_ni = 1'b0;
    mode = m; tap = t; osel = o; iodiv = d; prediv = p; cur_req = req;
    repeat (2) @(posedge clk_i);
    #1 check2("R1", io_clk, sys_clk, 1'b0, 1'b0);
    rst_ni = 1'b1;
    repeat (3) @(posedge clk_i);
    #1 check2("R1", io_clk, sys_clk, 1'b0, 1'b0);
    run_en = 1'b1;
    repeat (periods * 32 * (int'(p) + 1) + 2) @(posedge clk_i);
  endtask

  initial begin
    #(150000 * 5);
    fails++;
    $display("FAIL watchdog: run did not finish (got hang, expected completion)");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240));
    // R4 R3: delayed, tap 1, both outputs on delayed clock
    run_cfg(8'h00, 8'h00, 8'hA0, 3'd0, 3'd0, 3, "R4");
    // R3: clamped code 0xFF -> 31
    run_cfg(8'h00, 8'hFF, 8'hA0, 3'd0, 3'd0, 3, "R3");
    // R5 R3: 0x78 -> 16 (50% duty)
    run_cfg(8'h10, 8'h78, 8'h50, 3'd0, 3'd0, 3, "R5");
    // R2: duty tap 8 with pre-divide by 3
    run_cfg(8'h10, 8'h07, 8'h50, 3'd0, 3'd2, 3, "R2");
    // R8: divide by 3, tap 14
    run_cfg(8'h00, 8'h45, 8'hB0, 3'd2, 3'd0, 8, "R8");
    // R8 R2: divide by 4, tap 20, pre-divide by 2
    run_cfg(8'h00, 8'h9A, 8'hB0, 3'd3, 3'd1, 6, "R8");
    // R9: disabled
    run_cfg(8'h11, 8'h45, 8'h70, 3'd1, 3'd0, 2, "R9");
    // R6 R7: delayed select in duty mode, divided select in duty mode
    run_cfg(8'h10, 8'h03, 8'hB0, 3'd1, 3'd0, 2, "R6");
    run_cfg(8'h00, 8'h03, 8'h30, 3'd0, 3'd0, 2, "R7");
    // R10: mid-period tap change waits for boundary
    run_cfg(8'h00, 8'h03, 8'hA0, 3'd0, 3'd0, 1, "R10");
    do @(posedge clk_i); while (tick % 32 != 10);
    #1 tap = 8'h50;
    repeat (3 * 32) @(posedge clk_i);
    // seeded random mix
    for (int i = 0; i < 16; i++) begin
      logic [7:0] rm;
      rm = {3'b000, 1'($urandom), 3'b000, 1'(($urandom % 6) == 0)};
      run_cfg(rm, 8'($urandom), 8'($urandom), 3'($urandom), 3'($urandom), 3, "R4");
    end
    @(posedge clk_i); #1 run_en = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule